// File: doc/BRIEF.md
# Shifted-Operand Data-Processing ALU

This block is the execute stage of a 32-bit integer data path. The first operand comes straight from a source register. The second operand is either a register value or an immediate, and it always passes through a barrel shifter first. The shifter offers left and right logical shifts, an arithmetic right shift, a rotate, and a one-bit rotate through the incoming carry. The shift distance comes from an immediate field or from the low byte of a register.

The ALU then applies one of sixteen operations selected by a 4-bit opcode. These cover pass and inverted pass, addition and subtraction in both operand orders with or without carry, the bitwise operations, and four compare/test forms that only produce flags. It returns the result, a destination write enable, and the next negative/zero/carry/overflow flags.

All outputs are registered and appear one clock after an issue strobe. Operand fetch, instruction decode and flag storage stay with the caller, which feeds the current flags back in on every operation.

Top module: `shift_alu`

## Requirements
- R1: The outputs `res_valid`, `result`, `rd_we` and `flags_out` are registered. `res_valid` is high in the cycle after `op_valid` was sampled high. A synchronous reset clears all outputs to zero.
- R2: The arithmetic opcodes are: 0x4 add `a+b`, 0x5 add with carry `a+b+C`, 0x2 subtract `a-b`, 0x6 subtract with borrow `a-b-!C`, 0x3 reverse subtract `b-a`, and 0x7 reverse subtract with borrow `b-a-!C`. Here `a` is `rn_val`, `b` is the shifted operand and C is `flags_in[1]`.
- R3: The logical opcodes are: 0x0 AND, 0x1 XOR, 0xC OR, 0xE `a & ~b`, 0xD pass `b`, and 0xF pass `~b`.
- R4: The compare opcodes 0x8 (`a&b`), 0x9 (`a^b`), 0xA (`a-b`) and 0xB (`a+b`) always update the flags, whatever the value of `set_flags`. They put the computed value on `result` and never assert `rd_we`. Every other opcode asserts `rd_we` when it is issued.
- R5: The flag word is {N,Z,C,V} in bits [3:0]. When a logical or compare-logical opcode updates the flags, N is result bit 31, Z is set when the result is zero, C is the shifter carry-out, and V keeps `flags_in[0]`.
- R6: When an arithmetic opcode updates the flags, N and Z come from the result and C is the adder carry-out. For subtraction C=1 therefore means no borrow (1-1 gives Z=1, C=1). V is the carry into the top bit XOR the carry out of it.
- R7: With `set_flags` low, a non-compare opcode gives `flags_out` equal to `flags_in`.
- R8: Shift kinds are 0 left logical, 1 right logical, 2 right arithmetic and 3 rotate right. For a distance of 1 to 31 the shifter carry is the last bit shifted out; for a rotate it is the new bit 31.
- R9: An immediate distance of 0 has a special meaning for each kind. For kind 0 it passes the operand and the incoming carry through unchanged. For kinds 1 and 2 it means a distance of 32. For kind 3 it is a one-bit rotate that shifts C into bit 31, and bit 0 becomes the carry.
- R10: A register distance of 0 passes the operand and the incoming carry through unchanged. A logical shift by 32 gives 0, with carry equal to the last bit out. A logical shift by more than 32 gives 0 with carry 0. An arithmetic shift by 32 or more fills with the sign bit, and the carry is the sign bit. A rotate by a non-zero multiple of 32 keeps the operand, and the carry is bit 31.
- R11: A cycle with `op_valid` low gives `res_valid=0` and `rd_we=0` in the next cycle, and `result` and `flags_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue strobe for the operation on the inputs |
| opcode | input | 4 | Operation select |
| set_flags | input | 1 | Update flags from this operation |
| rn_val | input | DATA_W | First operand |
| op2_val | input | DATA_W | Second operand before shifting (register or immediate) |
| shift_kind | input | 2 | Shift kind |
| shift_by_reg | input | 1 | Take distance from `shift_reg` instead of `shift_imm` |
| shift_imm | input | log2(DATA_W) | Immediate shift distance |
| shift_reg | input | REG_AMT_W | Register shift distance (low byte) |
| flags_in | input | 4 | Current {N,Z,C,V} |
| res_valid | output | 1 | Result valid |
| result | output | DATA_W | Computed value |
| rd_we | output | 1 | Destination write enable |
| flags_out | output | 4 | Next {N,Z,C,V} |

## Verification
The bench builds the block with its default parameters: a 32-bit data width and an 8-bit register shift distance. With an 8-bit distance, register amounts of exactly 32, just past it (33, 40) and far past it (200) can all be applied. That brings the saturating logical, sign-fill and rotate-multiple corners within reach next to the immediate zero-distance encodings. A 32-bit word puts the signed overflow boundary at 0x7FFFFFFF and the borrow cases at their natural values.

// File: rtl/shift_alu_pkg.sv
package shift_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND      = 4'h0,
    OP_XOR      = 4'h1,
    OP_SUB      = 4'h2,
    OP_RSUB     = 4'h3,
    OP_ADD      = 4'h4,
    OP_ADDC     = 4'h5,
    OP_SUBC     = 4'h6,
    OP_RSUBC    = 4'h7,
    OP_TESTAND  = 4'h8,
    OP_TESTXOR  = 4'h9,
    OP_CMPSUB   = 4'hA,
    OP_CMPADD   = 4'hB,
    OP_OR       = 4'hC,
    OP_PASS     = 4'hD,
    OP_ANDNOT   = 4'hE,
    OP_PASSNOT  = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_SLL = 2'd0,
    SH_SRL = 2'd1,
    SH_SRA = 2'd2,
    SH_ROT = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Compare/test forms occupy opcodes 8..11
  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    case (op)
      OP_SUB, OP_RSUB, OP_ADD, OP_ADDC, OP_SUBC, OP_RSUBC,
      OP_CMPSUB, OP_CMPADD: return 1'b1;
      default:              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import shift_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input  logic [DATA_W-1:0]         operand,
  input  logic [1:0]                kind,
  input  logic                      by_reg,
  input  logic [$clog2(DATA_W)-1:0] imm_amt,
  input  logic [REG_AMT_W-1:0]      reg_amt,
  input  logic                      carry_in,
  output logic [DATA_W-1:0]         shifted,
  output logic                      carry_out
);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam int AMT_W   = (REG_AMT_W > SHAMT_W + 1) ? REG_AMT_W : SHAMT_W + 1;

  logic [AMT_W-1:0]      eff_amt;
  logic                  ext_rot;
  logic [DATA_W:0]       sll_t;
  logic [DATA_W:0]       srl_t;
  logic signed [DATA_W:0] sra_src;
  logic [DATA_W:0]       sra_t;
  logic [2*DATA_W-1:0]   rot_t;
  logic [DATA_W-1:0]     rot_res;

  // Effective distance: immediate 0 on right shifts stands for a full word
  always_comb begin
    eff_amt = by_reg ? AMT_W'(reg_amt) : AMT_W'(imm_amt);
    if (!by_reg && (imm_amt == '0) &&
        ((kind == SH_SRL) || (kind == SH_SRA)))
      eff_amt = AMT_W'(DATA_W);
  end

  assign ext_rot = !by_reg && (imm_amt == '0) && (kind == SH_ROT);

  // Widened shifts keep the last bit out beside the result
  assign sll_t   = {1'b0, operand} << eff_amt;
  assign srl_t   = {operand, 1'b0} >> eff_amt;
  assign sra_src = {operand, 1'b0};
  assign sra_t   = sra_src >>> eff_amt;
  assign rot_t   = {operand, operand} >> eff_amt[SHAMT_W-1:0];
  assign rot_res = rot_t[DATA_W-1:0];

  always_comb begin
    shifted   = operand;
    carry_out = carry_in;
    if (ext_rot) begin
      shifted   = {carry_in, operand[DATA_W-1:1]};
      carry_out = operand[0];
    end else if (eff_amt != '0) begin
      case (kind)
        SH_SLL: begin
          shifted   = sll_t[DATA_W-1:0];
          carry_out = sll_t[DATA_W];
        end
        SH_SRL: begin
          shifted   = srl_t[DATA_W:1];
          carry_out = srl_t[0];
        end
        SH_SRA: begin
          shifted   = sra_t[DATA_W:1];
          carry_out = sra_t[0];
        end
        default: begin
          shifted   = rot_res;
          carry_out = rot_res[DATA_W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  logic [DATA_W:0] full;
  logic            c_into_msb;

  assign full       = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  assign sum        = full[DATA_W-1:0];
  assign cout       = full[DATA_W];
  assign c_into_msb = a[DATA_W-1] ^ b[DATA_W-1] ^ full[DATA_W-1];
  assign ovf        = c_into_msb ^ cout;

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import shift_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] rn,
  input  logic [DATA_W-1:0] shb,
  input  logic              sh_carry,
  input  flags_t            flags_cur,
  output logic [DATA_W-1:0] value,
  output logic              write_en,
  output flags_t            flags_nxt
);
  logic [DATA_W-1:0] add_a, add_b, add_sum;
  logic              add_ci, add_co, add_v;
  logic [DATA_W-1:0] logic_val;
  logic              arith, update;

  // Operand steering: subtraction adds the inverse, carry doubles as not-borrow
  always_comb begin
    add_a  = rn;
    add_b  = shb;
    add_ci = 1'b0;
    case (alu_op_e'(opcode))
      OP_ADDC:           add_ci = flags_cur.c;
      OP_SUB, OP_CMPSUB: begin add_b = ~shb; add_ci = 1'b1; end
      OP_SUBC:           begin add_b = ~shb; add_ci = flags_cur.c; end
      OP_RSUB:           begin add_a = shb; add_b = ~rn; add_ci = 1'b1; end
      OP_RSUBC:          begin add_a = shb; add_b = ~rn; add_ci = flags_cur.c; end
      default: ;
    endcase
  end

  alu_adder #(.DATA_W(DATA_W)) adder_i (
    .a    (add_a),
    .b    (add_b),
    .cin  (add_ci),
    .sum  (add_sum),
    .cout (add_co),
    .ovf  (add_v)
  );

  always_comb begin
    case (alu_op_e'(opcode))
      OP_AND, OP_TESTAND: logic_val = rn & shb;
      OP_XOR, OP_TESTXOR: logic_val = rn ^ shb;
      OP_OR:              logic_val = rn | shb;
      OP_ANDNOT:          logic_val = rn & ~shb;
      OP_PASSNOT:         logic_val = ~shb;
      default:            logic_val = shb;
    endcase
  end

  assign arith    = op_is_arith(opcode);
  assign value    = arith ? add_sum : logic_val;
  assign write_en = !op_is_compare(opcode);
  assign update   = set_flags || op_is_compare(opcode);

  always_comb begin
    flags_nxt = flags_cur;
    if (update) begin
      flags_nxt.n = value[DATA_W-1];
      flags_nxt.z = (value == '0);
      flags_nxt.c = arith ? add_co : sh_carry;
      flags_nxt.v = arith ? add_v  : flags_cur.v;
    end
  end

endmodule

// File: rtl/shift_alu.sv
module shift_alu
  import shift_alu_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      op_valid,
  input  logic [3:0]                opcode,
  input  logic                      set_flags,
  input  logic [DATA_W-1:0]         rn_val,
  input  logic [DATA_W-1:0]         op2_val,
  input  logic [1:0]                shift_kind,
  input  logic                      shift_by_reg,
  input  logic [$clog2(DATA_W)-1:0] shift_imm,
  input  logic [REG_AMT_W-1:0]      shift_reg,
  input  logic [3:0]                flags_in,
  output logic                      res_valid,
  output logic [DATA_W-1:0]         result,
  output logic                      rd_we,
  output logic [3:0]                flags_out
);
  flags_t            flags_cur, flags_nxt;
  logic [DATA_W-1:0] shb, value;
  logic              sh_carry, write_en;

  assign flags_cur = flags_t'(flags_in);

  alu_shifter #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) shifter_i (
    .operand   (op2_val),
    .kind      (shift_kind),
    .by_reg    (shift_by_reg),
    .imm_amt   (shift_imm),
    .reg_amt   (shift_reg),
    .carry_in  (flags_cur.c),
    .shifted   (shb),
    .carry_out (sh_carry)
  );

  alu_datapath #(.DATA_W(DATA_W)) datapath_i (
    .opcode    (opcode),
    .set_flags (set_flags),
    .rn        (rn_val),
    .shb       (shb),
    .sh_carry  (sh_carry),
    .flags_cur (flags_cur),
    .value     (value),
    .write_en  (write_en),
    .flags_nxt (flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      rd_we     <= 1'b0;
      result    <= '0;
      flags_out <= '0;
    end else if (op_valid) begin
      res_valid <= 1'b1;
      rd_we     <= write_en;
      result    <= value;
      flags_out <= flags_nxt;
    end else begin
      res_valid <= 1'b0;
      rd_we     <= 1'b0;
    end
  end

endmodule

// File: rtl/shift_alu_chk.sv
module shift_alu_chk #(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [3:0]           opcode,
  input logic                 set_flags,
  input logic                 shift_by_reg,
  input logic [REG_AMT_W-1:0] shift_reg,
  input logic [3:0]           flags_in,
  input logic                 res_valid,
  input logic [DATA_W-1:0]    result,
  input logic                 rd_we,
  input logic [3:0]           flags_out
);
  import shift_alu_pkg::*;

  logic cmp_op, logic_op;
  assign cmp_op   = op_is_compare(opcode);
  assign logic_op = !op_is_arith(opcode);

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && cmp_op) |=> !rd_we);

  assert_nz_from_result_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (set_flags || cmp_op)) |=>
      (flags_out[3] == result[DATA_W-1]) && (flags_out[2] == (result == '0)));

  assert_logic_keeps_v_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && logic_op && (set_flags || cmp_op)) |=> flags_out[0] == $past(flags_in[0]));

  assert_flags_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !set_flags && !cmp_op) |=> flags_out == $past(flags_in));

  assert_zero_reg_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && logic_op && (set_flags || cmp_op) && shift_by_reg && shift_reg == '0)
      |=> flags_out[1] == $past(flags_in[1]));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!res_valid && !rd_we && $stable(result) && $stable(flags_out)));

endmodule

bind shift_alu shift_alu_chk #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .opcode       (opcode),
  .set_flags    (set_flags),
  .shift_by_reg (shift_by_reg),
  .shift_reg    (shift_reg),
  .flags_in     (flags_in),
  .res_valid    (res_valid),
  .result       (result),
  .rd_we        (rd_we),
  .flags_out    (flags_out)
);

// File: tb/shift_alu_tb_top.sv
`timescale 1ns/1ps
module shift_alu_tb_top;
  localparam int DW = 32;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [3:0]    opcode = '0;
  logic          set_flags = 1'b0;
  logic [DW-1:0] rn_val = '0;
  logic [DW-1:0] op2_val = '0;
  logic [1:0]    shift_kind = '0;
  logic          shift_by_reg = 1'b0;
  logic [4:0]    shift_imm = '0;
  logic [RW-1:0] shift_reg = '0;
  logic [3:0]    flags_in = '0;
  logic          res_valid;
  logic [DW-1:0] result;
  logic          rd_we;
  logic [3:0]    flags_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  shift_alu #(.DATA_W(DW), .REG_AMT_W(RW)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
    .set_flags(set_flags), .rn_val(rn_val), .op2_val(op2_val),
    .shift_kind(shift_kind), .shift_by_reg(shift_by_reg),
    .shift_imm(shift_imm), .shift_reg(shift_reg), .flags_in(flags_in),
    .res_valid(res_valid), .result(result), .rd_we(rd_we),
    .flags_out(flags_out)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one operation and check {valid, result, we, flags} one cycle later
  task automatic run_op(input logic [3:0] opc, input logic s,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] k, input logic br,
                        input logic [4:0] ia, input logic [7:0] ra,
                        input logic [3:0] fin, input logic [31:0] er,
                        input logic ew, input logic [3:0] ef, input string tag);
    logic [39:0] act, exp;
    @(negedge clk);
    op_valid = 1'b1; opcode = opc; set_flags = s; rn_val = a; op2_val = b;
    shift_kind = k; shift_by_reg = br; shift_imm = ia; shift_reg = ra;
    flags_in = fin;
    @(negedge clk);
    act = {2'b00, res_valid, result, rd_we, flags_out};
    exp = {2'b00, 1'b1, er, ew, ef};
    check(act == exp, tag, act, exp);
    op_valid = 1'b0;
  endtask

  task automatic test_reset();
    logic [39:0] act;
    act = {2'b00, res_valid, result, rd_we, flags_out};
    check(act == 40'h0, "R1 reset state", act, 40'h0);
  endtask

  task automatic test_arith();
    run_op(4'h4, 0, 32'h5, 32'h5, 2'd0, 0, 5'd1, 8'd0, 4'hF, 32'hF, 1, 4'hF, "R2 R7 add shifted, flags pass");
    run_op(4'h3, 1, 32'h77, 32'h0, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'hFFFFFF89, 1, 4'h8, "R2 R6 reverse subtract borrow");
    run_op(4'h2, 1, 32'h1, 32'h1, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h0, 1, 4'h6, "R6 subtract equal no borrow");
    run_op(4'h5, 1, 32'hFFFFFFFF, 32'h0, 2'd0, 0, 5'd0, 8'd0, 4'h2, 32'h0, 1, 4'h6, "R2 R6 add with carry wrap");
    run_op(4'h4, 1, 32'h7FFFFFFF, 32'h1, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h80000000, 1, 4'h9, "R6 signed overflow");
    run_op(4'h6, 1, 32'h5, 32'h3, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h1, 1, 4'h2, "R2 subtract with borrow");
    run_op(4'h7, 1, 32'h3, 32'hA, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h6, 1, 4'h2, "R2 reverse subtract with borrow");
  endtask

  task automatic test_compare();
    run_op(4'hA, 0, 32'h4, 32'h4, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h0, 0, 4'h6, "R4 compare-subtract equal");
    run_op(4'hB, 0, 32'hFFFFFFFF, 32'h1, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h0, 0, 4'h6, "R4 compare-add wrap");
    run_op(4'h8, 0, 32'hF0, 32'h0F, 2'd0, 0, 5'd0, 8'd0, 4'h3, 32'h0, 0, 4'h7, "R4 R5 test-and keeps C V");
    run_op(4'h9, 0, 32'h80000000, 32'h0, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h80000000, 0, 4'h8, "R4 test-xor negative");
  endtask

  task automatic test_logic();
    run_op(4'hC, 0, 32'h02040608, 32'h10305070, 2'd0, 0, 5'd0, 8'd0, 4'h5, 32'h12345678, 1, 4'h5, "R3 R7 or");
    run_op(4'hE, 1, 32'hF, 32'h5, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'hA, 1, 4'h0, "R3 and-not");
    run_op(4'h1, 1, 32'hFF, 32'h3, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'hFC, 1, 4'h0, "R3 xor");
    run_op(4'h0, 1, 32'h1234, 32'h3, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h0, 1, 4'h4, "R3 R5 and zero");
    run_op(4'hF, 1, 32'h0, 32'h0, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'hFFFFFFFF, 1, 4'h8, "R3 pass-not");
  endtask

  task automatic test_shift_imm();
    run_op(4'hD, 1, 32'h0, 32'h80000004, 2'd0, 0, 5'd1, 8'd0, 4'h0, 32'h8, 1, 4'h2, "R5 R8 left by 1 carry");
    run_op(4'hD, 1, 32'h0, 32'h18, 2'd1, 0, 5'd4, 8'd0, 4'h0, 32'h1, 1, 4'h2, "R8 logical right 4");
    run_op(4'hD, 1, 32'h0, 32'h80000008, 2'd2, 0, 5'd4, 8'd0, 4'h0, 32'hF8000000, 1, 4'hA, "R8 arithmetic right 4");
    run_op(4'hD, 1, 32'h0, 32'hA5, 2'd3, 0, 5'd8, 8'd0, 4'h0, 32'hA5000000, 1, 4'hA, "R8 rotate 8");
  endtask

  task automatic test_shift_zero();
    run_op(4'hD, 1, 32'h0, 32'h80000000, 2'd1, 0, 5'd0, 8'd0, 4'h0, 32'h0, 1, 4'h6, "R9 imm 0 logical right is 32");
    run_op(4'hD, 1, 32'h0, 32'h80000000, 2'd2, 0, 5'd0, 8'd0, 4'h0, 32'hFFFFFFFF, 1, 4'hA, "R9 imm 0 arithmetic is 32");
    run_op(4'hD, 1, 32'h0, 32'h3, 2'd3, 0, 5'd0, 8'd0, 4'h2, 32'h80000001, 1, 4'hA, "R9 imm 0 rotate through carry");
    run_op(4'hD, 1, 32'h0, 32'h4, 2'd0, 0, 5'd0, 8'd0, 4'h2, 32'h4, 1, 4'h2, "R9 imm 0 left keeps carry");
  endtask

  task automatic test_shift_reg();
    run_op(4'hD, 1, 32'h0, 32'h10, 2'd0, 1, 5'd0, 8'd0, 4'h2, 32'h10, 1, 4'h2, "R10 reg 0 keeps carry");
    run_op(4'hD, 1, 32'h0, 32'h1, 2'd0, 1, 5'd0, 8'd32, 4'h0, 32'h0, 1, 4'h6, "R10 left by 32");
    run_op(4'hD, 1, 32'h0, 32'h1, 2'd0, 1, 5'd0, 8'd33, 4'h2, 32'h0, 1, 4'h4, "R10 left by 33");
    run_op(4'hD, 1, 32'h0, 32'hFFFFFFFF, 2'd1, 1, 5'd0, 8'd40, 4'h2, 32'h0, 1, 4'h4, "R10 right by 40");
    run_op(4'hD, 1, 32'h0, 32'h80000000, 2'd2, 1, 5'd0, 8'd200, 4'h0, 32'hFFFFFFFF, 1, 4'hA, "R10 arithmetic by 200");
    run_op(4'hD, 1, 32'h0, 32'h80000001, 2'd3, 1, 5'd0, 8'd32, 4'h0, 32'h80000001, 1, 4'hA, "R10 rotate by 32");
    run_op(4'hD, 1, 32'h0, 32'hF1, 2'd3, 1, 5'd0, 8'd36, 4'h2, 32'h1000000F, 1, 4'h0, "R10 rotate by 36");
    run_op(4'hD, 1, 32'h0, 32'hC, 2'd1, 1, 5'd0, 8'd3, 4'h0, 32'h1, 1, 4'h2, "R8 register right by 3");
  endtask

  task automatic test_idle();
    logic [39:0] act, exp;
    run_op(4'h4, 1, 32'h10, 32'h20, 2'd0, 0, 5'd0, 8'd0, 4'h0, 32'h30, 1, 4'h0, "R2 add before idle");
    @(negedge clk);
    opcode = 4'h2; rn_val = 32'hDEAD; flags_in = 4'hF; set_flags = 1'b1;
    @(negedge clk);
    act = {2'b00, res_valid, result, rd_we, flags_out};
    exp = {2'b00, 1'b0, 32'h30, 1'b0, 4'h0};
    check(act == exp, "R11 idle holds outputs", act, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_arith();
    test_compare();
    test_logic();
    test_shift_imm();
    test_shift_zero();
    test_shift_reg();
    test_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule